// File: doc/BRIEF.md
# MDIO Management Master

This block is a register-driven master for the two-wire PHY management bus. Software programs it through four 32-bit registers on a plain valid/write port. The block then generates the management clock and shifts complete management frames to and from external PHYs over a tri-state data pin, which is split into output, output-enable and input. Both the short-address frame format (Clause 22) and the extended format with separate address frames (Clause 45) are supported. A configuration bit selects between them.

Each frame starts as a side effect of a register write:
- A write to the data register sends a write frame.
- A control write with the read bit set sends a read frame.
- In Clause 45 mode, a write to the address register sends an address frame.

While a frame is on the wire, a busy flag stays set and writes that could start or alter a frame are dropped. A read whose turnaround is not pulled low by a PHY is reported through an error flag, and the data register then holds 0xFFFF. Software polls busy between steps and reads the result from the data register.

Top module: `mdio_master`

## Requirements
- R1: After reset every register reads 0, `mdc` is low and `mdio_oe` is low.
- R2: Byte offset 0x0 is configuration: bits 31:2 read back as last written, bit 6 set selects Clause 45, bit 0 is read-only busy and bit 1 is read-only read-error. Offset 0x4 is control (bits 15:0), 0x8 data (15:0) and 0xC address (15:0); their upper bits read 0. A control write with bit 15 clear starts no frame.
- R3: A data-register write in Clause 22 mode sends 32 ones, start 01, opcode 01, the 5-bit PHY address from control bits 9:5, the 5-bit register from control bits 4:0, turnaround 10 and the 16 written bits, MSB first, with `mdio_oe` high for all 64 bits.
- R4: A control write with bit 15 set in Clause 22 mode sends start 01, opcode 10 and the addresses from that write. It releases `mdio_oe` for the last 18 bits and stores the 16 data bits sampled from the PHY into the data register.
- R5: In Clause 45 mode an address-register write sends start 00, opcode 00, port and device from control, turnaround 10 and the 16-bit address. In Clause 22 mode the same write only stores the value and starts no frame.
- R6: In Clause 45 mode a data write uses start 00, opcode 01, and a read uses start 00, opcode 11.
- R7: If the second turnaround bit sampled in a read is not 0, the read-error flag is set and data reads 0xFFFF. Each new read frame clears the flag.
- R8: Busy is set on the clock edge that accepts a starting write and stays set for exactly 64*CLK_DIV clocks. Outside a frame, `mdc` and `mdio_oe` are low.
- R9: `mdc` has period CLK_DIV clocks, and `mdio_o`/`mdio_oe` change only while `mdc` is low.
- R10: While busy, writes to control, data and address change neither those registers nor the running frame, and start no new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_valid | input | 1 | Register access strobe |
| reg_write | input | 1 | Access is a write when high |
| reg_addr | input | 4 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in (pin level) |

## Verification
The assertions assume that `mdio_i` follows `mdio_o` whenever `mdio_oe` is high, as on a real shared pin. The bench resolves its pin model in exactly that way and drives the PHY side only while the master has released the line. They also assume that reset is held for at least one clock and that CLK_DIV is even and at least 2. The bench keeps the default ratio and holds reset for several clocks. The PHY model changes its bit only after a falling `mdc`, so the sampled values never depend on a race with the master's sampling edge.

// File: rtl/mdio_master.sv
`timescale 1ns/1ps
module mdio_master #(
  parameter int CLK_DIV = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_valid,
  input  logic        reg_write,
  input  logic [3:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  localparam int HALF = CLK_DIV / 2;
  localparam int CW   = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
  localparam logic [CW-1:0] RISE_AT = CW'(HALF - 1);
  localparam logic [CW-1:0] FALL_AT = CW'(CLK_DIV - 1);

  logic [31:2] cfg_q;
  logic [15:0] ctl_q, dat_q, adr_q, cap_q;
  logic        busy_q, err_q, mdc_q, oe_q, rd_q, ta_bad_q;
  logic [63:0] sh_q;
  logic [CW-1:0] cnt_q;
  logic [5:0]  bit_q;

  wire c45    = cfg_q[6];
  wire wr_any = reg_valid && reg_write;
  wire wr_ok  = wr_any && !busy_q;
  wire go_adr = wr_ok && reg_addr == 4'hC && c45;
  wire go_wr  = wr_ok && reg_addr == 4'h8;
  wire go_rd  = wr_ok && reg_addr == 4'h4 && reg_wdata[15];
  wire go     = go_adr || go_wr || go_rd;
  wire rise   = busy_q && cnt_q == RISE_AT;
  wire fall   = busy_q && cnt_q == FALL_AT;

  wire [4:0]  f_phy = go_rd ? reg_wdata[9:5] : ctl_q[9:5];
  wire [4:0]  f_reg = go_rd ? reg_wdata[4:0] : ctl_q[4:0];
  wire [1:0]  f_st  = c45 ? 2'b00 : 2'b01;
  wire [1:0]  f_op  = go_adr ? 2'b00 : go_wr ? 2'b01 : (c45 ? 2'b11 : 2'b10);
  wire [15:0] f_dat = go_rd ? 16'hFFFF : reg_wdata[15:0];
  wire [63:0] frame = {32'hFFFF_FFFF, f_st, f_op, f_phy, f_reg, 2'b10, f_dat};

  assign mdc     = mdc_q;
  assign mdio_oe = oe_q;
  assign mdio_o  = sh_q[63];

  always_comb begin
    case (reg_addr)
      4'h0:    reg_rdata = {cfg_q, err_q, busy_q};
      4'h4:    reg_rdata = {16'h0, ctl_q};
      4'h8:    reg_rdata = {16'h0, dat_q};
      4'hC:    reg_rdata = {16'h0, adr_q};
      default: reg_rdata = 32'h0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q    <= '0;
      ctl_q    <= '0;
      dat_q    <= '0;
      adr_q    <= '0;
      cap_q    <= '0;
      busy_q   <= 1'b0;
      err_q    <= 1'b0;
      mdc_q    <= 1'b0;
      oe_q     <= 1'b0;
      rd_q     <= 1'b0;
      ta_bad_q <= 1'b0;
      sh_q     <= '0;
      cnt_q    <= '0;
      bit_q    <= '0;
    end else begin
      if (wr_any && reg_addr == 4'h0) cfg_q <= reg_wdata[31:2];
      if (wr_ok && reg_addr == 4'h4) ctl_q <= reg_wdata[15:0];
      if (wr_ok && reg_addr == 4'h8) dat_q <= reg_wdata[15:0];
      if (wr_ok && reg_addr == 4'hC) adr_q <= reg_wdata[15:0];
      if (go) begin
        busy_q <= 1'b1;
        sh_q   <= frame;
        cnt_q  <= '0;
        bit_q  <= '0;
        oe_q   <= 1'b1;
        mdc_q  <= 1'b0;
        rd_q   <= go_rd;
        if (go_rd) begin
          err_q    <= 1'b0;
          ta_bad_q <= 1'b0;
        end
      end else if (busy_q) begin
        cnt_q <= fall ? '0 : cnt_q + 1'b1;
        if (rise) begin
          mdc_q <= 1'b1;
          if (rd_q && bit_q == 6'd47) ta_bad_q <= mdio_i;
          if (rd_q && bit_q >= 6'd48) cap_q <= {cap_q[14:0], mdio_i};
        end
        if (fall) begin
          mdc_q <= 1'b0;
          sh_q  <= {sh_q[62:0], 1'b0};
          bit_q <= bit_q + 1'b1;
          if (rd_q && bit_q == 6'd45) oe_q <= 1'b0;
          if (bit_q == 6'd63) begin
            busy_q <= 1'b0;
            oe_q   <= 1'b0;
            if (rd_q) begin
              err_q <= ta_bad_q;
              dat_q <= ta_bad_q ? 16'hFFFF : cap_q;
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/mdio_master_chk.sv
`timescale 1ns/1ps
module mdio_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_valid,
  input logic       reg_write,
  input logic [3:0] reg_addr,
  input logic       mdc,
  input logic       mdio_o,
  input logic       mdio_oe,
  input logic       busy_q
);
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> (!mdc && !mdio_oe));

  a_r8_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && reg_valid && reg_write && reg_addr == 4'h8) |=> busy_q);

  a_r8_start_drives: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> (mdio_oe && !mdc));

  a_r8_end_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> $fell(mdc));

  a_r9_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe)));
endmodule

bind mdio_master mdio_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_valid(reg_valid), .reg_write(reg_write),
  .reg_addr(reg_addr), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
  .busy_q(busy_q)
);

// File: tb/mdio_master_test.sv
`timescale 1ns/1ps
module mdio_master_test;
  localparam int DIV = 4;
  logic clk = 0, rst_n = 0;
  logic reg_valid = 0, reg_write = 0;
  logic [3:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic mdc, mdio_o, mdio_oe, mdio_i;
  logic phy_drv = 0, phy_val = 0;
  logic resp_en = 0, resp_ta = 0;
  logic [15:0] resp_data = 0;
  logic [63:0] cap = 0, oet = 0;
  int nbits = 0, nchk = 0, nfail = 0, cycles = 0;
  longint cyc = 0, last_rise = 0, mdc_per = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc++;

  assign mdio_i = mdio_oe ? mdio_o : (phy_drv ? phy_val : 1'b1);

  mdio_master #(.CLK_DIV(DIV)) uut (.*);

  always @(posedge mdc) begin
    cap = {cap[62:0], mdio_i};
    oet = {oet[62:0], mdio_oe};
    nbits++;
    mdc_per = cyc - last_rise;
    last_rise = cyc;
  end

  always @(negedge mdc) begin
    if (resp_en && nbits == 47) begin
      phy_drv = resp_ta; phy_val = 1'b0;
    end else if (resp_en && nbits >= 48 && nbits <= 63) begin
      phy_drv = 1'b1; phy_val = resp_data[63 - nbits];
    end else begin
      phy_drv = 1'b0;
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_valid = 1; reg_write = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_valid = 0; reg_write = 0; reg_addr = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_idle;
    cycles = 0;
    reg_addr = 0;
    #1;
    while (reg_rdata[0] && cycles < 5000) begin
      cycles++;
      @(negedge clk);
      #1;
    end
  endtask

  task automatic run_frame(input logic [3:0] a, input logic [31:0] d,
                           input logic en, input logic ta, input logic [15:0] rdat);
    nbits = 0; resp_en = en; resp_ta = ta; resp_data = rdat;
    wr(a, d);
    wait_idle();
    resp_en = 0;
  endtask

  function automatic logic [63:0] fr(input logic [1:0] st, input logic [1:0] op,
      input logic [4:0] p, input logic [4:0] r, input logic [1:0] ta, input logic [15:0] d);
    return {32'hFFFF_FFFF, st, op, p, r, ta, d};
  endfunction

  localparam logic [63:0] OE_WR = {64{1'b1}};
  localparam logic [63:0] OE_RD = {{46{1'b1}}, 18'b0};

  task automatic t_reset;
    logic [31:0] v;
    for (int a = 0; a < 16; a += 4) begin
      rd(4'(a), v);
      chk("R1 reg reset", 64'(v), 64'h0);
    end
    chk("R1 mdc/oe reset", {62'h0, mdc, mdio_oe}, 64'h0);
  endtask

  task automatic t_regs;
    logic [31:0] v;
    wr(4'h0, 32'h0080_950B);
    rd(4'h0, v);
    chk("R2 cfg readback ro bits", 64'(v), 64'h0080_9508);
    wr(4'h4, 32'hFFFF_00A3);
    rd(4'h4, v);
    chk("R2 ctl readback", 64'(v), 64'h0000_00A3);
    rd(4'h0, v);
    chk("R2 ctl no read bit no frame", 64'(v[0]), 64'h0);
    wr(4'hC, 32'h0000_4321);
    rd(4'h0, v);
    chk("R5 c22 addr write no busy", 64'(v[0]), 64'h0);
    rd(4'hC, v);
    chk("R5 c22 addr stored", 64'(v), 64'h4321);
    chk("R5 c22 addr no mdc", 64'(nbits), 64'h0);
  endtask

  task automatic t_c22_write;
    logic [31:0] v;
    run_frame(4'h8, 32'h1234, 0, 0, 0);
    chk("R3 c22 write frame", cap, fr(2'b01, 2'b01, 5'd5, 5'd3, 2'b10, 16'h1234));
    chk("R3 oe all bits", oet, OE_WR);
    chk("R8 busy length", 64'(cycles), 64'(64 * DIV));
    chk("R9 mdc period", 64'(mdc_per), 64'(DIV));
    rd(4'h8, v);
    chk("R3 data kept", 64'(v), 64'h1234);
  endtask

  task automatic t_c22_read_ok(input logic [15:0] d);
    logic [31:0] v;
    run_frame(4'h4, 32'h0000_80A2, 1, 1, d);
    chk("R4 c22 read frame", cap, fr(2'b01, 2'b10, 5'd5, 5'd2, 2'b10, d));
    chk("R4 turnaround release", oet, OE_RD);
    rd(4'h8, v);
    chk("R4 read data", 64'(v), 64'(d));
    rd(4'h0, v);
    chk("R7 err clear on good read", 64'(v[1:0]), 64'h0);
  endtask

  task automatic t_c22_read_fail;
    logic [31:0] v;
    run_frame(4'h4, 32'h0000_80A2, 0, 0, 0);
    chk("R7 no-phy frame", cap, fr(2'b01, 2'b10, 5'd5, 5'd2, 2'b11, 16'hFFFF));
    rd(4'h8, v);
    chk("R7 data all ones", 64'(v), 64'hFFFF);
    rd(4'h0, v);
    chk("R7 err flag", 64'(v), 64'h0080_950A);
  endtask

  task automatic t_busy_ignore;
    logic [31:0] v;
    nbits = 0;
    wr(4'h8, 32'h5555);
    wr(4'h8, 32'h9999);
    wr(4'h4, 32'h0000_83FF);
    wr(4'hC, 32'h7777);
    wait_idle();
    chk("R10 frame unchanged", cap, fr(2'b01, 2'b01, 5'd5, 5'd2, 2'b10, 16'h5555));
    rd(4'h8, v);
    chk("R10 data not overwritten", 64'(v), 64'h5555);
    rd(4'h4, v);
    chk("R10 ctl not overwritten", 64'(v), 64'h80A2);
    rd(4'hC, v);
    chk("R10 addr not overwritten", 64'(v), 64'h4321);
    repeat (40) @(negedge clk);
    #1 reg_addr = 0;
    #1 chk("R10 no second frame", {63'(nbits), reg_rdata[0]}, {63'd64, 1'b0});
  endtask

  task automatic t_c45;
    logic [31:0] v;
    wr(4'h0, 32'h0080_9548);
    wr(4'h4, 32'h0000_00E1);
    run_frame(4'hC, 32'h0010, 0, 0, 0);
    chk("R5 c45 address frame", cap, fr(2'b00, 2'b00, 5'd7, 5'd1, 2'b10, 16'h0010));
    run_frame(4'h8, 32'hA5A5, 0, 0, 0);
    chk("R6 c45 write frame", cap, fr(2'b00, 2'b01, 5'd7, 5'd1, 2'b10, 16'hA5A5));
    chk("R6 c45 write oe", oet, OE_WR);
    run_frame(4'h4, 32'h0000_80E1, 1, 1, 16'h5A5A);
    chk("R6 c45 read frame", cap, fr(2'b00, 2'b11, 5'd7, 5'd1, 2'b10, 16'h5A5A));
    chk("R6 c45 read oe", oet, OE_RD);
    rd(4'h8, v);
    chk("R6 c45 read data", 64'(v), 64'h5A5A);
    run_frame(4'h4, 32'h0000_80E1, 1, 0, 16'h1111);
    rd(4'h8, v);
    chk("R7 c45 ta high data", 64'(v), 64'hFFFF);
    rd(4'h0, v);
    chk("R7 c45 ta high err", 64'(v[1]), 64'h1);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_regs();
    t_c22_write();
    t_c22_read_ok(16'hBEEF);
    t_c22_read_fail();
    t_c22_read_ok(16'h0042);
    t_busy_ignore();
    t_c45();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    #(8 * 150000);
    nchk++; nfail++;
    $display("FAIL watchdog expired act=hung exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule